// File: doc/BRIEF.md
# Multiphase Hysteretic Phase Splitter

This block turns the single digital result of a shared hysteretic comparator into the gate-drive commands of a buck converter with one, two or three phases. When the comparator reports that the sensed current has fallen to the lower threshold and no phase is conducting, the splitter starts the next phase in its rotation. That phase stays on until the comparator reports the upper threshold, or until a cycle-by-cycle current-limit flag cuts the on-time short.

For every output it drives, the splitter also selects the matching current-sense input. When no phase is on, all select lines are low, so the shared sense node carries the average of the channels. Two strap inputs report whether the second or third sense input is tied high. From them the block picks three-phase, two-phase or single-phase operation. After every output edge a blanking window of a set number of clock cycles hides comparator noise. Every output is registered.

Top module: `phase_splitter`

## Requirements
- R1: While `rst` is high, `pwm` and `mux_sel` are 0 at the next clock edge, and the first phase started after reset is channel 1 (`pwm` = 3'b001).
- R2: When no phase is on, `en` is high, no blanking is active and `cmp_on` is 1 at a clock edge, the next phase in the rotation is driven high at that edge.
- R3: When a phase is on, no blanking is active and `cmp_on` is 0 at a clock edge, all of `pwm` goes low at that edge.
- R4: When a phase is on and `ilim` is 1 at a clock edge, all of `pwm` goes low at that edge, even inside a blanking window.
- R5: With both straps low (three-phase), successive phases come in the order `pwm` = 001, 010, 100, 001 (bit 0 is channel 1).
- R6: With `cs3_strap` high and `cs2_strap` low (two-phase), phases alternate 001, 010, 001, and `pwm[2]` never goes high.
- R7: With `cs2_strap` high, whatever the state of `cs3_strap` (single-phase), every turn-on drives `pwm` = 3'b101, and `pwm[1]` never goes high.
- R8: `mux_sel` is one-hot while a phase is on and zero when none is on. It selects the conducting channel (bit 0 = channel 1). In single-phase mode it selects channel 1.
- R9: After each `pwm` edge, the next `BLANK_CYC` clock edges ignore `cmp_on`. With `BLANK_CYC` = 4, a phase whose comparator drops right after turn-on stays high for 5 cycles. A comparator pulse that starts and ends inside the window changes nothing. After a turn-off, the next turn-on comes no sooner than 5 cycles later.
- R10: When `en` is low at a clock edge, `pwm` and `mux_sel` become 0 at that edge. The rotation restarts at channel 1 once `en` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable, active high |
| cs2_strap | input | 1 | Channel-2 sense input tied high (selects single-phase) |
| cs3_strap | input | 1 | Channel-3 sense input tied high (selects two-phase) |
| cmp_on | input | 1 | Hysteretic comparator: 1 = at/below lower threshold, 0 = at/above upper threshold |
| ilim | input | 1 | Cycle-by-cycle current-limit flag |
| pwm | output | 3 | Phase drive commands, bit 0 = channel 1 |
| mux_sel | output | 3 | One-hot current-sense select, zero selects the averaged input |

## Verification
The comparator is toggled in full on/off cycles under each strap combination, including both straps high. Comparing the sequence of `pwm` patterns across these runs separates the three-, two- and single-phase rotations and the matching `mux_sel`. Timed patterns follow. The comparator drops the cycle after a turn-on, rises again right after a turn-off, or glitches inside the blanking window. These expose the blanking length on both edges and whether noise inside the window is really ignored. The current-limit flag is raised inside the blanking window, which distinguishes a limit that overrides blanking from a comparator-driven turn-off. Dropping `en` in the middle of a phase shows both the immediate release and the restart of the rotation at channel 1.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int NUM_CH = 3;
  typedef logic [1:0] ch_idx_t;
  typedef enum logic [1:0] {
    MODE_TRI  = 2'd0,
    MODE_DUO  = 2'd1,
    MODE_SOLO = 2'd2
  } phase_mode_e;
endpackage

// File: rtl/phs_mode_dec.sv
module phs_mode_dec
  import phs_pkg::*;
(
  input  logic        cs2_strap,
  input  logic        cs3_strap,
  output phase_mode_e mode
);
  // channel-2 strap dominates: single phase regardless of channel-3 strap
  always_comb begin
    if (cs2_strap)      mode = MODE_SOLO;
    else if (cs3_strap) mode = MODE_DUO;
    else                mode = MODE_TRI;
  end
endmodule

// File: rtl/phs_rotor.sv
module phs_rotor
  import phs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        advance,
  input  phase_mode_e mode,
  output ch_idx_t     fire_ch
);
  ch_idx_t ptr_q;
  ch_idx_t last_ch;
  ch_idx_t next_ch;

  always_comb begin
    case (mode)
      MODE_DUO:  last_ch = ch_idx_t'(1);
      MODE_SOLO: last_ch = ch_idx_t'(0);
      default:   last_ch = ch_idx_t'(NUM_CH - 1);
    endcase
    // a pointer left beyond the range of a new mode folds back to channel 1
    fire_ch = (ptr_q > last_ch) ? ch_idx_t'(0) : ptr_q;
    next_ch = (fire_ch == last_ch) ? ch_idx_t'(0) : fire_ch + ch_idx_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  ptr_q <= '0;
    else if (advance)  ptr_q <= next_ch;
  end
endmodule

// File: rtl/phs_blank.sv
module phs_blank #(
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  output logic idle
);
  localparam int CNT_W = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt_q <= '0;
    else if (load)         cnt_q <= CNT_W'(BLANK_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/phase_splitter.sv
module phase_splitter
  import phs_pkg::*;
#(
  parameter int BLANK_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       cs2_strap,
  input  logic       cs3_strap,
  input  logic       cmp_on,
  input  logic       ilim,
  output logic [2:0] pwm,
  output logic [2:0] mux_sel
);
  phase_mode_e mode;
  ch_idx_t     fire_ch;
  logic        blank_idle;
  logic        on_q;
  logic        turn_on;
  logic        turn_off;
  logic [NUM_CH-1:0] pat_pwm;
  logic [NUM_CH-1:0] pat_sel;
  logic [NUM_CH-1:0] pwm_q;
  logic [NUM_CH-1:0] sel_q;

  phs_mode_dec u_mode (
    .cs2_strap (cs2_strap),
    .cs3_strap (cs3_strap),
    .mode      (mode)
  );

  phs_rotor u_rotor (
    .clk     (clk),
    .rst     (rst),
    .clear   (!en),
    .advance (turn_on),
    .mode    (mode),
    .fire_ch (fire_ch)
  );

  phs_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst   (rst),
    .clear (!en),
    .load  (turn_on || turn_off),
    .idle  (blank_idle)
  );

  assign turn_on  = en && !on_q && blank_idle && cmp_on;
  assign turn_off = en && on_q && (ilim || (blank_idle && !cmp_on));

  // per-channel drive pattern for the channel selected by the rotor
  for (genvar g = 0; g < NUM_CH; g++) begin : g_pat
    always_comb begin
      if (mode == MODE_SOLO) begin
        pat_pwm[g] = (g == 0) || (g == NUM_CH - 1);
        pat_sel[g] = (g == 0);
      end else begin
        pat_pwm[g] = (fire_ch == ch_idx_t'(g));
        pat_sel[g] = (fire_ch == ch_idx_t'(g));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      on_q  <= 1'b0;
      pwm_q <= '0;
      sel_q <= '0;
    end else if (turn_on) begin
      on_q  <= 1'b1;
      pwm_q <= pat_pwm;
      sel_q <= pat_sel;
    end else if (turn_off) begin
      on_q  <= 1'b0;
      pwm_q <= '0;
      sel_q <= '0;
    end
  end

  assign pwm     = pwm_q;
  assign mux_sel = sel_q;
endmodule

// File: rtl/phs_checker.sv
module phs_checker #(
  parameter int BLANK_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       cs2_strap,
  input logic       ilim,
  input logic [2:0] pwm,
  input logic [2:0] mux_sel
);
  // R4: current limit ends an on-time at once
  p_ilim_cut_r4: assert property (@(posedge clk) disable iff (rst)
    (en && ilim && (pwm != 3'b000)) |=> (pwm == 3'b000));

  // R7: middle output never starts while single-phase strap is set
  p_mid_solo_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm[1]) |-> !$past(cs2_strap));

  // R8: select is one-hot, within the driven outputs, and present exactly when driving
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mux_sel) && ((mux_sel & ~pwm) == 3'b000));
  p_sel_present_r8: assert property (@(posedge clk) disable iff (rst)
    (pwm != 3'b000) == (mux_sel != 3'b000));

  // R10: disable clears everything
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm == 3'b000) && (mux_sel == 3'b000));

  // R9: the edge right after an output change is blanked
  if (BLANK_CYC >= 1) begin : g_blank_chk
    p_blank_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (pwm != $past(pwm)) |=> (pwm == $past(pwm)) || $past(ilim) || !$past(en) || $past(rst));
  end
endmodule

bind phase_splitter phs_checker #(.BLANK_CYC(BLANK_CYC)) u_phs_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .cs2_strap (cs2_strap),
  .ilim      (ilim),
  .pwm       (pwm),
  .mux_sel   (mux_sel)
);

// File: tb/tb_phase_splitter.sv
`timescale 1ns/1ps
module tb_phase_splitter;
  localparam int BLANK = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       cs2_strap = 1'b0;
  logic       cs3_strap = 1'b0;
  logic       cmp_on = 1'b0;
  logic       ilim = 1'b0;
  logic [2:0] pwm;
  logic [2:0] mux_sel;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  phase_splitter #(.BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst(rst), .en(en), .cs2_strap(cs2_strap), .cs3_strap(cs3_strap),
    .cmp_on(cmp_on), .ilim(ilim), .pwm(pwm), .mux_sel(mux_sel)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full on/off cycle; checks the pattern driven and the sense select
  task automatic fire(input logic [2:0] exp_pwm, input logic [2:0] exp_sel, input string req);
    int n = 0;
    cmp_on = 1'b1;
    while (pwm == 3'b000 && n < 40) begin step(); n++; end
    chk(pwm == exp_pwm, req, pwm, exp_pwm);
    chk(mux_sel == exp_sel, "R8", mux_sel, exp_sel);
    cmp_on = 1'b0;
    n = 0;
    while (pwm != 3'b000 && n < 40) begin step(); n++; end
    chk(pwm == 3'b000 && mux_sel == 3'b000, "R3", pwm, 0);
  endtask

  task automatic restart();
    en = 1'b0; cmp_on = 1'b0; ilim = 1'b0;
    step();
    en = 1'b1;
    for (int i = 0; i < BLANK + 2; i++) step();
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; cmp_on = 1'b1;
    step(); step();
    chk(pwm == 3'b000, "R1", pwm, 0);
    chk(mux_sel == 3'b000, "R1", mux_sel, 0);
    cmp_on = 1'b0; rst = 1'b0;
    step();
    fire(3'b001, 3'b001, "R1");
  endtask

  task automatic t_tri();
    cs2_strap = 1'b0; cs3_strap = 1'b0;
    restart();
    fire(3'b001, 3'b001, "R5");
    fire(3'b010, 3'b010, "R5");
    fire(3'b100, 3'b100, "R5");
    fire(3'b001, 3'b001, "R5");
  endtask

  task automatic t_duo();
    cs2_strap = 1'b0; cs3_strap = 1'b1;
    restart();
    fire(3'b001, 3'b001, "R6");
    fire(3'b010, 3'b010, "R6");
    fire(3'b001, 3'b001, "R6");
    fire(3'b010, 3'b010, "R6");
  endtask

  task automatic t_solo();
    cs2_strap = 1'b1; cs3_strap = 1'b0;
    restart();
    fire(3'b101, 3'b001, "R7");
    fire(3'b101, 3'b001, "R7");
    cs3_strap = 1'b1;
    fire(3'b101, 3'b001, "R7");
    cs2_strap = 1'b0; cs3_strap = 1'b0;
  endtask

  // R9: on-width with comparator dropping at once, then off-to-on spacing
  task automatic t_blank_width();
    int width = 0;
    int gap = 0;
    restart();
    cmp_on = 1'b1;
    step();
    chk(pwm == 3'b001, "R2", pwm, 1);
    cmp_on = 1'b0;
    while (pwm != 3'b000 && width < 40) begin step(); width++; end
    chk(width == BLANK + 1, "R9", width, BLANK + 1);
    cmp_on = 1'b1;
    while (pwm == 3'b000 && gap < 40) begin step(); gap++; end
    chk(gap == BLANK + 1, "R9", gap, BLANK + 1);
    chk(pwm == 3'b010, "R2", pwm, 2);
    cmp_on = 1'b0;
    for (int i = 0; i < 2 * BLANK + 2; i++) step();
  endtask

  // R9: a comparator glitch inside the window is ignored
  task automatic t_blank_glitch();
    restart();
    cmp_on = 1'b1;
    step();
    cmp_on = 1'b0;
    step(); step();
    cmp_on = 1'b1;
    for (int i = 0; i < BLANK + 4; i++) step();
    chk(pwm == 3'b001, "R9", pwm, 1);
    cmp_on = 1'b0;
    step();
    chk(pwm == 3'b000, "R3", pwm, 0);
  endtask

  // R4: current limit inside the blanking window still ends the on-time
  task automatic t_ilim();
    restart();
    cmp_on = 1'b1;
    step();
    chk(pwm == 3'b001, "R2", pwm, 1);
    ilim = 1'b1;
    step();
    chk(pwm == 3'b000, "R4", pwm, 0);
    chk(mux_sel == 3'b000, "R4", mux_sel, 0);
    ilim = 1'b0;
    cmp_on = 1'b0;
    for (int i = 0; i < BLANK + 2; i++) step();
  endtask

  // R10: disable mid-phase, then rotation restarts at channel 1
  task automatic t_enable();
    restart();
    fire(3'b001, 3'b001, "R10");
    cmp_on = 1'b1;
    while (pwm == 3'b000) step();
    chk(pwm == 3'b010, "R10", pwm, 2);
    en = 1'b0;
    step();
    chk(pwm == 3'b000 && mux_sel == 3'b000, "R10", pwm, 0);
    cmp_on = 1'b0;
    en = 1'b1;
    step();
    fire(3'b001, 3'b001, "R10");
  endtask

  initial begin
    t_reset();
    t_tri();
    t_duo();
    t_solo();
    t_blank_width();
    t_blank_glitch();
    t_ilim();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule